// File: doc/BRIEF.md
# MESI Snooping Cache Controller

This block keeps one processor's small direct-mapped cache coherent with its peers on a shared snooping bus. Each line holds one data word, a tag and one of four coherence states: Invalid, Exclusive (sole copy, clean), Shared (other copies may exist, clean) or Modified (sole copy, dirty). Processor reads and writes that can be served locally finish with no bus activity. Other accesses become bus transactions: a read fill, a read-for-ownership, or a write-back of a dirty victim. The controller also watches every transaction that other masters place on the bus. It answers with a shared indication and, when it holds the only current copy, a flush of its data.

On a read fill the controller samples a wired-OR shared line. If no other cache claims the line, the fill lands in Exclusive, and a later write to that line upgrades it silently. The bus carries one transaction at a time, so a grant to this controller never coincides with a snooped transaction. Snoop responses (shared and flush) appear one cycle after the snooped transaction is presented.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid. `cpu_ready`, `bus_req`, `shared_out` and `flush_valid` are low, and a snooped read then gets no shared response.
- R2: A processor read that misses raises `bus_req` with `bus_cmd` = 1 (read fill) for the requested address. If `shared_in` is low in the grant cycle the line is installed Exclusive; if it is high, Shared. The word on `bus_rdata` is returned on `cpu_rdata` with a one-cycle `cpu_ready` pulse.
- R3: In the cycle after a snooped read (`snp_cmd` = 1) that matches a valid line, `shared_out` is high. A snooped read that misses, and any snooped read-for-ownership, leave it low.
- R4: A processor write to an Exclusive line completes with no bus request, and the line becomes Modified.
- R5: A processor write to a Shared line, or one that misses, raises `bus_req` with `bus_cmd` = 2 (read-for-ownership). On the grant the line becomes Modified and holds the written word.
- R6: A snooped read that matches a Modified line drives `flush_valid` with the line's word on `flush_data` one cycle later, and the line becomes Shared.
- R7: A snooped read-for-ownership (`snp_cmd` = 2) that matches a Modified line flushes the word and invalidates the line. One that matches a Shared or Exclusive line invalidates it with no flush.
- R8: Reads that hit in Modified, Exclusive or Shared, and writes that hit in Modified, finish with no bus request. A read returns the most recent word stored in the line.
- R9: A miss whose victim line is Modified first issues a write-back (`bus_cmd` = 3) carrying the victim's address and word, and then the fill for the new address. A clean victim is dropped with no write-back.
- R10: A snooped read that matches an Exclusive line moves it to Shared with no flush.
- R11: A snooped transaction to the index of a pending processor request takes priority. If the request is waiting for a grant, `bus_req` is low in the next cycle, and the request is evaluated again against the updated line before it is reissued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request, held until granted |
| bus_cmd | output | 2 | 1 read fill, 2 read-for-ownership, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DATA_W | Fill word, valid with the grant |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding |
| snp_addr | input | ADDR_W | Snooped address |
| shared_in | input | 1 | Wired-OR shared line, sampled at the fill grant |
| shared_out | output | 1 | This cache's contribution to the shared line |
| flush_valid | output | 1 | Dirty data is being supplied |
| flush_data | output | DATA_W | Flushed word |

## Verification
The bench walks one line through every state edge and proves each state at the ports by the traffic the next access makes. A write to an Exclusive line that raised a request would show an unexpected read-for-ownership. A line left Modified after a snooped read would later write silently instead of requesting ownership. A missing flush or write-back shows up as a stale word on a later refill. A conflict miss is driven both with a dirty victim, which must produce a write-back before the fill, and with a clean victim, which must not. A snoop is injected while a write is waiting for its grant. A controller that ignored the snoop would keep `bus_req` high, and one that lost the request would never complete the write.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WB = 2'd3} bus_cmd_t;
endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_idx,
  output line_st_t         a_state,
  output logic [TAG_W-1:0] a_tag,
  input  logic             a_we,
  input  line_st_t         a_wstate,
  input  logic [TAG_W-1:0] a_wtag,
  input  logic [IDX_W-1:0] b_idx,
  output line_st_t         b_state,
  output logic [TAG_W-1:0] b_tag,
  input  logic             b_we,
  input  line_st_t         b_wstate
);
  localparam int LINES = 1 << IDX_W;

  line_st_t         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  // per-line state registers; processor port and snoop port may both write
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g] <= ST_I;
      end else if (b_we && b_idx == IDX_W'(g)) begin
        st_q[g] <= b_wstate;
      end else if (a_we && a_idx == IDX_W'(g)) begin
        st_q[g] <= a_wstate;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (a_we) tag_q[a_idx] <= a_wtag;
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];

  // R11: the controller must never let both ports update one line in a cycle
  p_one_writer_r11: assert property (@(posedge clk) disable iff (rst)
    !(a_we && b_we && a_idx == b_idx));
endmodule

// File: rtl/mesi_data_ram.sv
module mesi_data_ram #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_t          line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              upd_we_o,
  output line_st_t          upd_state_o,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_data_o
);
  logic hit, sh_n, fl_n;

  always_comb begin
    hit         = snp_valid_i && (line_state_i != ST_I) && (line_tag_i == snp_tag_i);
    upd_we_o    = 1'b0;
    upd_state_o = line_state_i;
    sh_n        = 1'b0;
    fl_n        = 1'b0;
    if (hit) begin
      case (bus_cmd_t'(snp_cmd_i))
        CMD_RD: begin
          sh_n = 1'b1;
          fl_n = (line_state_i == ST_M);
          if (line_state_i == ST_M || line_state_i == ST_E) begin
            upd_we_o    = 1'b1;
            upd_state_o = ST_S;
          end
        end
        CMD_RDX: begin
          fl_n        = (line_state_i == ST_M);
          upd_we_o    = 1'b1;
          upd_state_o = ST_I;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shared_o     <= 1'b0;
      flush_o      <= 1'b0;
      flush_data_o <= '0;
    end else begin
      shared_o     <= sh_n;
      flush_o      <= fl_n;
      flush_data_o <= fl_n ? line_data_i : '0;
    end
  end

  // R3: shared is only ever raised in answer to a snooped read
  p_shared_on_read_r3: assert property (@(posedge clk) disable iff (rst)
    shared_o |-> $past(snp_valid_i && snp_cmd_i == CMD_RD));
  // R6: flushed data can only come from a dirty line
  p_flush_from_dirty_r6: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> $past(line_state_i == ST_M));
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              shared_in,
  output logic              shared_out,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_LOOK, F_WAIT} fsm_t;

  fsm_t              fsm_q, fsm_n;
  logic              op_we;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic [IDX_W-1:0]  op_idx, snp_idx;
  logic [TAG_W-1:0]  op_tag, snp_tag;

  line_st_t          a_state, b_state, wa_state, sb_state;
  logic [TAG_W-1:0]  a_tag, b_tag, wa_tag;
  logic [DATA_W-1:0] a_data, b_data, wd_data;
  logic              wa_en, wd_en, sb_we;

  logic              rdy_n, req_n;
  logic [1:0]        cmd_n;
  logic [ADDR_W-1:0] baddr_n;
  logic [DATA_W-1:0] rdata_n, bwdata_n;
  logic              snp_same, a_hit, gnt_done;

  assign op_idx  = op_addr[IDX_W-1:0];
  assign op_tag  = op_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  mesi_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .a_idx(op_idx), .a_state(a_state), .a_tag(a_tag),
    .a_we(wa_en), .a_wstate(wa_state), .a_wtag(wa_tag),
    .b_idx(snp_idx), .b_state(b_state), .b_tag(b_tag),
    .b_we(sb_we), .b_wstate(sb_state)
  );

  mesi_data_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(wd_en), .widx(op_idx), .wdata(wd_data),
    .ra_idx(op_idx), .ra_data(a_data),
    .rb_idx(snp_idx), .rb_data(b_data)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_tag_i(snp_tag),
    .line_state_i(b_state), .line_tag_i(b_tag), .line_data_i(b_data),
    .upd_we_o(sb_we), .upd_state_o(sb_state),
    .shared_o(shared_out), .flush_o(flush_valid), .flush_data_o(flush_data)
  );

  assign snp_same = snp_valid && (snp_idx == op_idx);
  assign a_hit    = (a_state != ST_I) && (a_tag == op_tag);
  assign gnt_done = bus_req && bus_gnt;

  always_comb begin
    fsm_n    = fsm_q;
    rdy_n    = 1'b0;
    rdata_n  = cpu_rdata;
    req_n    = bus_req;
    cmd_n    = bus_cmd;
    baddr_n  = bus_addr;
    bwdata_n = bus_wdata;
    wa_en    = 1'b0;
    wa_state = a_state;
    wa_tag   = a_tag;
    wd_en    = 1'b0;
    wd_data  = op_wdata;
    case (fsm_q)
      F_IDLE: if (cpu_req) fsm_n = F_LOOK;
      F_LOOK: begin
        if (!snp_same) begin
          if (a_hit && !op_we) begin
            rdy_n   = 1'b1;
            rdata_n = a_data;
            fsm_n   = F_IDLE;
          end else if (a_hit && (a_state == ST_M || a_state == ST_E)) begin
            wa_en    = 1'b1;
            wa_state = ST_M;
            wd_en    = 1'b1;
            rdy_n    = 1'b1;
            rdata_n  = op_wdata;
            fsm_n    = F_IDLE;
          end else begin
            req_n    = 1'b1;
            fsm_n    = F_WAIT;
            baddr_n  = op_addr;
            bwdata_n = '0;
            if (!a_hit && a_state == ST_M) begin
              cmd_n    = CMD_WB;
              baddr_n  = {a_tag, op_idx};
              bwdata_n = a_data;
            end else begin
              cmd_n = op_we ? CMD_RDX : CMD_RD;
            end
          end
        end
      end
      F_WAIT: begin
        if (gnt_done) begin
          req_n = 1'b0;
          cmd_n = CMD_NONE;
          wa_en = 1'b1;
          case (bus_cmd_t'(bus_cmd))
            CMD_WB: begin
              wa_state = ST_I;
              fsm_n    = F_LOOK;
            end
            CMD_RD: begin
              wa_tag   = op_tag;
              wa_state = shared_in ? ST_S : ST_E;
              wd_en    = 1'b1;
              wd_data  = bus_rdata;
              rdy_n    = 1'b1;
              rdata_n  = bus_rdata;
              fsm_n    = F_IDLE;
            end
            default: begin
              wa_tag   = op_tag;
              wa_state = ST_M;
              wd_en    = 1'b1;
              rdy_n    = 1'b1;
              rdata_n  = op_wdata;
              fsm_n    = F_IDLE;
            end
          endcase
        end else if (snp_same) begin
          req_n = 1'b0;
          cmd_n = CMD_NONE;
          fsm_n = F_LOOK;
        end
      end
      default: fsm_n = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= F_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      bus_req   <= 1'b0;
      bus_cmd   <= CMD_NONE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      op_we     <= 1'b0;
      op_addr   <= '0;
      op_wdata  <= '0;
    end else begin
      fsm_q     <= fsm_n;
      cpu_ready <= rdy_n;
      cpu_rdata <= rdata_n;
      bus_req   <= req_n;
      bus_cmd   <= cmd_n;
      bus_addr  <= baddr_n;
      bus_wdata <= bwdata_n;
      if (fsm_q == F_IDLE && cpu_req) begin
        op_we    <= cpu_we;
        op_addr  <= cpu_addr;
        op_wdata <= cpu_wdata;
      end
    end
  end

  // R8: completion is a single-cycle pulse
  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R2: a raised request always carries a real command
  p_cmd_known_r2: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_cmd != CMD_NONE);
  // R4: a write to an Exclusive line finishes without touching the bus
  p_silent_upgrade_r4: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == F_LOOK && !snp_same && op_we && a_state == ST_E && a_tag == op_tag)
      |=> (cpu_ready && !bus_req));
  // R11: a snoop to the pending index withdraws the waiting request
  p_withdraw_r11: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == F_WAIT && snp_same && !bus_gnt) |=> !bus_req);
  // R9: after a write-back the request is reconsidered, never completed
  p_wb_then_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (gnt_done && bus_cmd == CMD_WB) |=> (!cpu_ready && fsm_q == F_LOOK));
endmodule

// File: tb/mesi_cache_ctrl_tb.sv
module mesi_cache_ctrl_tb;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam logic [1:0] C_RD = 2'd1, C_RDX = 2'd2, C_WB = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_gnt = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic shared_in = 0;
  logic shared_out, flush_valid;
  logic [DW-1:0] flush_data;

  int checks = 0, errors = 0;
  bit hold = 0, sh_cfg = 0, done = 0;
  logic [DW-1:0] mem [1 << AW];
  logic [DW-1:0] coh [1 << AW];

  typedef struct { logic [1:0] cmd; logic [AW-1:0] addr; logic [DW-1:0] data; } bus_item_t;
  typedef struct { bit is_rd; logic [DW-1:0] data; } rd_item_t;
  bus_item_t exp_bus[$];
  rd_item_t  exp_rd[$];

  always #10 clk = ~clk;

  mesi_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3)) u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .shared_in(shared_in), .shared_out(shared_out),
    .flush_valid(flush_valid), .flush_data(flush_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic want_bus(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_item_t it;
    it.cmd = cmd; it.addr = a; it.data = d;
    exp_bus.push_back(it);
  endtask

  // bus responder and transaction monitor
  always @(negedge clk) begin
    if (bus_gnt) begin
      bus_gnt = 1'b0;
    end else if (bus_req && !hold && !rst) begin
      if (exp_bus.size() == 0) begin
        check(1'b0, "R8", "unexpected bus transaction cmd", {30'd0, bus_cmd}, 32'd0);
      end else begin
        bus_item_t e;
        e = exp_bus.pop_front();
        check(bus_cmd == e.cmd, "R2/R5/R9", "bus command", {30'd0, bus_cmd}, {30'd0, e.cmd});
        check(bus_addr == e.addr, "R2/R5/R9", "bus address", {22'd0, bus_addr}, {22'd0, e.addr});
        if (e.cmd == C_WB)
          check(bus_wdata == e.data, "R9", "write-back word", bus_wdata, e.data);
      end
      if (bus_cmd == C_WB) mem[bus_addr] = bus_wdata;
      bus_rdata = mem[bus_addr];
      shared_in = sh_cfg;
      bus_gnt   = 1'b1;
    end
  end

  // completion monitor
  always @(negedge clk) begin
    if (cpu_ready) begin
      if (exp_rd.size() == 0) begin
        check(1'b0, "R8", "unexpected completion", cpu_rdata, 32'd0);
      end else begin
        rd_item_t r;
        r = exp_rd.pop_front();
        if (r.is_rd) check(cpu_rdata == r.data, "R8", "read data", cpu_rdata, r.data);
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    rd_item_t r;
    if (we) coh[a] = d;
    r.is_rd = !we; r.data = coh[a];
    exp_rd.push_back(r);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do @(negedge clk); while (!cpu_ready);
    cpu_req = 1'b0;
    check(exp_bus.size() == 0, req, "expected bus traffic seen", exp_bus.size(), 32'd0);
    exp_bus.delete();
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input bit e_sh,
                       input bit e_fl, input logic [DW-1:0] e_d, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    check(shared_out == e_sh, req, "shared_out", {31'd0, shared_out}, {31'd0, e_sh});
    check(flush_valid == e_fl, req, "flush_valid", {31'd0, flush_valid}, {31'd0, e_fl});
    if (e_fl) begin
      check(flush_data == e_d, req, "flush_data", flush_data, e_d);
      mem[a] = flush_data;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [AW-1:0] A = 10'h011, B = 10'h019, C = 10'h022, D = 10'h02A;

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = 32'hC0DE_0000 | i;
      coh[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!cpu_ready && !bus_req, "R1", "ready/req after reset", {30'd0, cpu_ready, bus_req}, 32'd0);
    check(!shared_out && !flush_valid, "R1", "snoop outputs after reset", {30'd0, shared_out, flush_valid}, 32'd0);
    snoop(C_RD, A, 0, 0, '0, "R1");

    // R2 miss -> Exclusive, then R4 silent write, R8 hits
    sh_cfg = 0;
    want_bus(C_RD, A, '0);  cpu_op(0, A, '0, "R2");
    cpu_op(1, A, 32'h1111_0001, "R4");
    cpu_op(0, A, '0, "R8");
    cpu_op(1, A, 32'h1111_0002, "R8");

    // R6 snooped read on Modified -> flush, Shared; R3 shared asserted
    snoop(C_RD, A, 1, 1, 32'h1111_0002, "R6");
    cpu_op(0, A, '0, "R8");
    want_bus(C_RDX, A, '0); cpu_op(1, A, 32'h1111_0003, "R5");

    // R7 snooped read-for-ownership on Modified
    snoop(C_RDX, A, 0, 1, 32'h1111_0003, "R7");
    sh_cfg = 1;
    want_bus(C_RD, A, '0);  cpu_op(0, A, '0, "R7");
    cpu_op(0, A, '0, "R8");
    // R7 snooped read-for-ownership on Shared, no flush
    snoop(C_RDX, A, 0, 0, '0, "R7");
    sh_cfg = 0;
    want_bus(C_RD, A, '0);  cpu_op(0, A, '0, "R2");

    // R10 snooped read on Exclusive -> Shared, no flush
    snoop(C_RD, A, 1, 0, '0, "R10");
    want_bus(C_RDX, A, '0); cpu_op(1, A, 32'h1111_0004, "R10");

    // R9 dirty victim written back before fill; clean victim dropped
    want_bus(C_WB, A, 32'h1111_0004);
    want_bus(C_RD, B, '0);  cpu_op(0, B, '0, "R9");
    want_bus(C_RD, A, '0);  cpu_op(0, A, '0, "R9");

    // R3 snooped read that misses
    snoop(C_RD, C, 0, 0, '0, "R3");

    // R11 snoop to the pending index withdraws the request
    hold = 1;
    want_bus(C_RDX, C, '0);
    fork
      cpu_op(1, C, 32'h1111_0005, "R11");
      begin
        do @(negedge clk); while (!bus_req);
        snoop(C_RDX, D, 0, 0, '0, "R11");
        check(!bus_req, "R11", "request withdrawn after snoop", {31'd0, bus_req}, 32'd0);
        hold = 0;
      end
    join
    cpu_op(0, C, '0, "R11");

    repeat (3) @(negedge clk);
    check(exp_rd.size() == 0, "R8", "all completions seen", exp_rd.size(), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule